// File: doc/BRIEF.md
# Reseedable Dual-LFSR XOR Bit Generator

This block produces one pseudo-random bit per clock from two Fibonacci shift registers of unequal length: a 49-bit primary and a 42-bit secondary. Both registers take their starting state from seeds supplied at run time. A one-cycle load strobe captures fresh seeds, and the sequence restarts from them. In dual mode the emitted bit is the XOR of the two register outputs. In single mode only the primary register drives the stream, but both registers keep stepping.

A reseed tracker counts the bits emitted since the last load. Once a programmable budget is used up, it raises a request. The default budget is twice the primary length, 98 bits. The request asks the surrounding system for a new seed before an observer can collect enough output to rebuild the register state. Two copies of the block that are given identical seeds emit identical streams, so paired devices can derive matching bit streams.

Top module: `dual_lfsr_xor_gen`

## Requirements
- R1: After reset and until the first seed load, `bit_valid` and `reseed_req` are both 0.
- R2: The cycle in which `seed_load` is 1 shows `bit_valid` = 0. A load takes priority over shifting. From the next cycle, `bit_valid` is 1 and the first bit emitted comes from the freshly loaded state.
- R3: The primary register shifts toward its MSB. Its new LSB is bit 48 XOR bit 8, which is the polynomial x^49+x^9+1. Its output bit is bit 48.
- R4: The secondary register shifts toward its MSB. Its new LSB is the XOR of bits 41, 40, 19 and 18, which is the polynomial x^42+x^41+x^20+x^19+1. Its output bit is bit 41.
- R5: With `dual_mode` = 1, `bit_out` is the primary output bit XOR the secondary output bit. With `dual_mode` = 0, `bit_out` is the primary output bit alone. Both registers advance on every valid cycle whatever the mode, and the mode may change between bits.
- R6: An all-zero seed for either register is loaded as the value 1, with only the LSB set.
- R7: `reseed_req` rises in the cycle after the RESEED_BITS-th valid bit following a load. It stays high until the next load, and bit generation continues meanwhile.
- R8: A seed load clears `reseed_req` and restarts the bit count from zero.
- R9: Loading the same seeds again reproduces the same bit stream from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | One-cycle strobe that loads both seeds |
| seed_pri | input | 49 | Seed for the primary register |
| seed_sec | input | 42 | Seed for the secondary register |
| dual_mode | input | 1 | 1: XOR of both registers, 0: primary only |
| bit_out | output | 1 | Generated bit, meaningful when `bit_valid` is 1 |
| bit_valid | output | 1 | A new bit is presented this cycle |
| reseed_req | output | 1 | Bit budget since the last load is spent |

## Verification
The stream is compared against an independent model for several seed patterns: dense mixed values, a single set bit, all ones, and a seed with sparse low bits. Between them, these patterns separate errors in the two tap sets and an off-by-one in the shift direction. Runs in both modes, including a mode switch partway through a stream, show whether the secondary register keeps stepping while it is unused. Zero seeds, a load in the middle of a stream, and a run past the 98-bit budget and back again test the lock-up guard, the load priority and the tracker's set and clear edges. A reload of the same seeds tests that the stream reproduces.

// File: rtl/lfsr_xor_pkg.sv
package lfsr_xor_pkg;
  localparam int unsigned PRI_LEN = 49;
  localparam int unsigned SEC_LEN = 42;

  // Feedback masks: bit i set means register bit i feeds the XOR.
  localparam logic [PRI_LEN-1:0] PRI_TAPS = (49'd1 << 48) | (49'd1 << 8);
  localparam logic [SEC_LEN-1:0] SEC_TAPS = (42'd1 << 41) | (42'd1 << 40)
                                          | (42'd1 << 19) | (42'd1 << 18);

  typedef enum logic {MODE_SINGLE = 1'b0, MODE_DUAL = 1'b1} gen_mode_e;

  // Combine register outputs according to the selected mode.
  function automatic logic mix_bits(gen_mode_e mode, logic pri_b, logic sec_b);
    return (mode == MODE_DUAL) ? (pri_b ^ sec_b) : pri_b;
  endfunction
endpackage

// File: rtl/lfsr_fib_core.sv
module lfsr_fib_core #(
  parameter int unsigned LEN = 49,
  parameter logic [LEN-1:0] TAPS = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [LEN-1:0] seed,
  input  logic           shift,
  output logic           out_bit
);
  logic [LEN-1:0] state_q;
  logic [LEN-1:0] seed_safe;
  logic           fb_bit;

  // Lock-up guard: an empty seed becomes 1.
  function automatic logic [LEN-1:0] sanitize(logic [LEN-1:0] s);
    return (s == '0) ? {{(LEN-1){1'b0}}, 1'b1} : s;
  endfunction

  function automatic logic parity_taps(logic [LEN-1:0] s);
    return ^(s & TAPS);
  endfunction

  assign seed_safe = sanitize(seed);
  assign fb_bit    = parity_taps(state_q);
  assign out_bit   = state_q[LEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= {{(LEN-1){1'b0}}, 1'b1};
    else if (load)  state_q <= seed_safe;
    else if (shift) state_q <= {state_q[LEN-2:0], fb_bit};
  end

  // R6: register never holds zero
  a_r6_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  // R2: load captures the seed (zero replaced by one)
  a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (state_q == (($past(seed) == '0) ? {{(LEN-1){1'b0}}, 1'b1} : $past(seed))));
  // R3/R4: shifting moves every bit one place toward the MSB
  a_r3_shift_move: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> (state_q[LEN-1:1] == $past(state_q[LEN-2:0])));
  // R2: idle register holds its value
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift && !load) |=> $stable(state_q));
endmodule

// File: rtl/reseed_tracker.sv
module reseed_tracker #(
  parameter int unsigned LIMIT = 98
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bit_done,
  output logic req
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] count_q;
  logic          last_bit;

  assign last_bit = bit_done && (count_q == LIM - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      req     <= 1'b0;
    end else if (clear) begin
      count_q <= '0;
      req     <= 1'b0;
    end else begin
      if (bit_done && count_q != LIM) count_q <= count_q + CW'(1);
      if (last_bit) req <= 1'b1;
    end
  end

  // R7: count saturates at the budget
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= LIM);
  // R7: request holds until a load
  a_r7_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !clear) |=> req);
  // R8: load clears request
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!req && count_q == '0));
endmodule

// File: rtl/dual_lfsr_xor_gen.sv
module dual_lfsr_xor_gen
  import lfsr_xor_pkg::*;
#(
  parameter int unsigned RESEED_BITS = 2 * PRI_LEN
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               seed_load,
  input  logic [PRI_LEN-1:0] seed_pri,
  input  logic [SEC_LEN-1:0] seed_sec,
  input  logic               dual_mode,
  output logic               bit_out,
  output logic               bit_valid,
  output logic               reseed_req
);
  logic      armed_q;
  logic      pri_bit;
  logic      sec_bit;
  logic      step_en;
  gen_mode_e mode;

  assign mode      = gen_mode_e'(dual_mode);
  assign step_en   = armed_q && !seed_load;
  assign bit_valid = step_en;
  assign bit_out   = mix_bits(mode, pri_bit, sec_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed_q <= 1'b0;
    else if (seed_load) armed_q <= 1'b1;
  end

  lfsr_fib_core #(.LEN(PRI_LEN), .TAPS(PRI_TAPS)) u_pri (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(seed_pri),
    .shift(step_en), .out_bit(pri_bit));

  lfsr_fib_core #(.LEN(SEC_LEN), .TAPS(SEC_TAPS)) u_sec (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(seed_sec),
    .shift(step_en), .out_bit(sec_bit));

  reseed_tracker #(.LIMIT(RESEED_BITS)) u_track (
    .clk(clk), .rst_n(rst_n), .clear(seed_load), .bit_done(step_en),
    .req(reseed_req));

  // R1: no request without a load ever seen
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> (!reseed_req && !bit_valid));
  // R2: after a load, bits flow unless another load arrives
  a_r2_valid_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> (armed_q));
endmodule

// File: tb/dual_lfsr_xor_gen_bench.sv
module dual_lfsr_xor_gen_bench;
  localparam int LIMIT = 98;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seed_load = 1'b0;
  logic [48:0] seed_pri = '0;
  logic [41:0] seed_sec = '0;
  logic        dual_mode = 1'b0;
  logic        bit_out, bit_valid, reseed_req;

  int checks = 0;
  int failures = 0;
  logic [48:0] ma;
  logic [41:0] mb;
  int since_load = 0;
  logic cap [0:39];

  always #2.5 clk = ~clk;

  dual_lfsr_xor_gen u_dual_lfsr_xor_gen (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_pri(seed_pri),
    .seed_sec(seed_sec), .dual_mode(dual_mode), .bit_out(bit_out),
    .bit_valid(bit_valid), .reseed_req(reseed_req));

  localparam logic [48:0] VA [0:3] = '{49'h10F0F3C3CA5A5, 49'h0000000000001,
                                       49'h1FFFFFFFFFFFF, 49'h0DEADBEEF1234};
  localparam logic [41:0] VB [0:3] = '{42'h2ABCDEF0123, 42'h3FFFFFFFFFF,
                                       42'h00000000001, 42'h1357924680A};
  localparam logic        VM [0:3] = '{1'b1, 1'b0, 1'b1, 1'b1};

  function automatic logic [48:0] step_a(logic [48:0] s);
    return {s[47:0], s[48] ^ s[8]};
  endfunction
  function automatic logic [41:0] step_b(logic [41:0] s);
    return {s[40:0], s[41] ^ s[40] ^ s[19] ^ s[18]};
  endfunction

  task automatic chk(logic ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; load strobe lasts exactly one clock.
  task automatic do_load(logic [48:0] a, logic [41:0] b);
    seed_load = 1'b1; seed_pri = a; seed_sec = b;
    #1;
    chk(bit_valid === 1'b0, "R2 valid low during load", bit_valid, 0);
    @(negedge clk);
    seed_load = 1'b0;
    ma = (a == '0) ? 49'd1 : a;   // R6 model
    mb = (b == '0) ? 42'd1 : b;
    since_load = 0;
  endtask

  task automatic run_bits(int n, string tag);
    for (int i = 0; i < n; i++) begin
      logic e;
      #1;
      e = dual_mode ? (ma[48] ^ mb[41]) : ma[48];
      chk(bit_valid === 1'b1, {tag, " valid"}, bit_valid, 1);
      chk(bit_out === e, {tag, " R3 R4 R5 bit"}, bit_out, e);
      chk(reseed_req === (since_load >= LIMIT), "R7 R8 request level",
          reseed_req, since_load >= LIMIT);
      @(negedge clk);
      ma = step_a(ma); mb = step_b(mb); since_load++;
    end
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset
    for (int i = 0; i < 4; i++) begin
      #1;
      chk(bit_valid === 1'b0, "R1 valid idle", bit_valid, 0);
      chk(reseed_req === 1'b0, "R1 req idle", reseed_req, 0);
      @(negedge clk);
    end

    // Vector table walk (R3 R4 R5)
    for (int v = 0; v < 4; v++) begin
      dual_mode = VM[v];
      do_load(VA[v], VB[v]);
      run_bits(60, "vector");
    end

    // R5: mode switch mid-stream, secondary keeps stepping
    dual_mode = 1'b1;
    do_load(49'h0A5A5F00F1234, 42'h0F0F1234567);
    run_bits(10, "R5 dual");
    dual_mode = 1'b0;
    run_bits(10, "R5 single");
    dual_mode = 1'b1;
    run_bits(10, "R5 dual again");

    // R6: zero seeds
    do_load('0, '0);
    run_bits(60, "R6 zero seed");

    // R2: load mid-stream takes priority
    do_load(49'h123456789ABCD, 42'h2468ACE1357);
    run_bits(7, "R2 before reload");
    do_load(49'h1F00000000001, 42'h00000F00001);
    run_bits(20, "R2 after reload");

    // R7/R8: budget expiry, persistence, clear
    do_load(49'h1B00B1E5CAFE0, 42'h3C0FFEE0001);
    run_bits(LIMIT + 6, "R7 budget");
    do_load(49'h0000012345678, 42'h1000000F00F);
    run_bits(LIMIT - 1, "R8 restart");

    // R9: reload reproduces stream
    do_load(49'h0777766665555, 42'h11122233344);
    for (int i = 0; i < 40; i++) begin
      #1; cap[i] = bit_out; @(negedge clk);
    end
    do_load(49'h0777766665555, 42'h11122233344);
    for (int i = 0; i < 40; i++) begin
      #1;
      chk(bit_out === cap[i], "R9 reproducible", bit_out, cap[i]);
      @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule